// File: doc/BRIEF.md
# Descriptor Ring Pointer and Completion Status Unit

This unit keeps the bookkeeping for a circular queue of transfer descriptors that software fills and a data engine drains. Software programs the queue base address, the end pointer and the write pointer over a simple 32-bit register bus. The engine pulses a consume strobe each time it finishes a descriptor, and the unit steps the read pointer forward, wrapping it at the end pointer. Pointers count in units, and one descriptor spans a fixed stride of units (two by default). The end pointer therefore holds the stride times the number of ring entries.

The engine also reports three events: an upstream transfer completed, a downstream transfer completed, and a downstream transfer hit a dirty or error condition. Each event sets a sticky status bit. Software clears these bits by writing ones to them. A registered interrupt is raised when any status bit is set and its enable bit is also set. Two decoded outputs report the fate of the active transfer. Failure applies whenever the dirty bit is set. Success applies only when the completion bit matches the direction that software marked in the control register.

Software returns the read pointer to zero by writing a fixed key value to the read-pointer register. A ring restart writes the end pointer, then the key, then a zero write pointer, then control, then the base.

Top module: `ring_cmdq_tracker`

## Requirements
- R1: After reset, every register reads zero, the head pointer is zero, and irq_o, xfer_ok_o, xfer_fail_o and ds_256_o are low.
- R2: Register word addresses are 0 base, 1 end pointer, 2 write pointer, 3 read pointer, 4 control and 5 status. Base, end and write pointer read back what was written, with the pointers truncated to 16 bits. Control keeps only bit 0 (direction, 1 = upstream), bits 16..18 (interrupt enables) and bit 20 (256-byte downstream size), so writing all ones reads back 0x00170001.
- R3: A consume strobe while the read pointer differs from the write pointer advances the read pointer by the stride (2) on the next clock edge.
- R4: A consume strobe while the read pointer equals the write pointer leaves the read pointer unchanged.
- R5: When the read pointer plus the stride reaches or passes the end pointer, a consume sets the read pointer to 0.
- R6: Writing 0xEE882266 to the read-pointer register sets the read pointer to 0. Any other value written there has no effect.
- R7: When the key write and a consume fall in the same cycle, the read pointer becomes 0.
- R8: Pulses on up_done_i, dn_done_i and dn_dirty_i set status bits 16, 17 and 18. These bits stay set after the pulse ends.
- R9: Writing ones to status bits clears them, and writing zeros leaves them unchanged. An event that arrives in the same cycle as its clear leaves the bit set.
- R10: irq_o is high one clock after some status bit and its enable (control bit 16, 17 or 18) are both set. It stays low when no set status bit is enabled.
- R11: xfer_fail_o equals status bit 18. xfer_ok_o is high only when bit 18 is clear and the completion bit for the direction in control bit 0 is set (bit 16 when upstream, bit 17 when downstream).
- R12: ds_256_o follows control bit 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| consume_i | input | 1 | Engine finished one descriptor |
| up_done_i | input | 1 | Upstream completion event |
| dn_done_i | input | 1 | Downstream completion event |
| dn_dirty_i | input | 1 | Downstream dirty or error event |
| queue_base_o | output | 32 | Programmed queue base address |
| head_ptr_o | output | 16 | Current read pointer |
| irq_o | output | 1 | Registered interrupt |
| xfer_ok_o | output | 1 | Active transfer completed in its own direction without error |
| xfer_fail_o | output | 1 | Active transfer reported dirty |
| ds_256_o | output | 1 | 256-byte downstream size selected |

## Verification
Two pairs of functions can land in the same clock cycle. A key write can coincide with an engine consume, and a status clear can coincide with a new event on the same bit. The bench provokes each pair by driving the register write and the engine strobe together in one cycle. It then reads the register back: the read pointer must be zero, and the status bit must still be set. The bench also checks the direction gating of completions and the rule that dirty outranks completion. It does this by raising events one at a time and sampling the decoded outputs after each one.

// File: rtl/ring_pkg.sv
package ring_pkg;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_BASE  = 3'd0,
        RA_END   = 3'd1,
        RA_WRPTR = 3'd2,
        RA_RDPTR = 3'd3,
        RA_CTRL  = 3'd4,
        RA_STAT  = 3'd5
    } reg_addr_e;

    localparam logic [31:0] RD_RESET_KEY = 32'hEE88_2266;

    // bit positions shared by control (enables) and status
    localparam int EV_LSB   = 16;
    localparam int CT_DIR   = 0;
    localparam int CT_DS256 = 20;

    // index 0 = upstream done, 1 = downstream done, 2 = downstream dirty
    typedef struct packed {
        logic dirty;
        logic dn;
        logic up;
    } evt_t;
endpackage

// File: rtl/ring_rdptr.sv
module ring_rdptr #(
    parameter int PTR_W  = 16,
    parameter int STRIDE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             consume_i,
    input  logic             key_wr_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic [PTR_W-1:0] end_ptr_i,
    output logic [PTR_W-1:0] rd_ptr_o
);
    localparam logic [PTR_W:0] STEP = (PTR_W+1)'(STRIDE);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
    } st_t;

    st_t s_d, s_q;
    logic [PTR_W:0] nxt;

    always_comb begin
        s_d = s_q;
        nxt = {1'b0, s_q.rd} + STEP;
        if (key_wr_i) begin
            s_d.rd = '0;
        end else if (consume_i && (s_q.rd != wr_ptr_i)) begin
            if (nxt >= {1'b0, end_ptr_i}) s_d.rd = '0;
            else                          s_d.rd = nxt[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_ptr_o = s_q.rd;
endmodule

// File: rtl/ring_status.sv
module ring_status
    import ring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt_i,
    input  logic clr_wr_i,
    input  evt_t clr_mask_i,
    input  evt_t en_i,
    output evt_t status_o,
    output logic irq_o
);
    typedef struct packed {
        evt_t stat;
        logic irq;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_wr_i) s_d.stat = s_q.stat & ~clr_mask_i;
        s_d.stat = s_d.stat | evt_i;
        s_d.irq  = |(s_q.stat & en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = s_q.stat;
    assign irq_o    = s_q.irq;
endmodule

// File: rtl/ring_cmdq_tracker.sv
module ring_cmdq_tracker
    import ring_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int STRIDE = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]           reg_wdata_i,
    output logic [31:0]           reg_rdata_o,
    input  logic                  consume_i,
    input  logic                  up_done_i,
    input  logic                  dn_done_i,
    input  logic                  dn_dirty_i,
    output logic [31:0]           queue_base_o,
    output logic [PTR_W-1:0]      head_ptr_o,
    output logic                  irq_o,
    output logic                  xfer_ok_o,
    output logic                  xfer_fail_o,
    output logic                  ds_256_o
);
    localparam int PAD_W = 32 - PTR_W;

    typedef struct packed {
        logic [31:0]      base;
        logic [PTR_W-1:0] end_p;
        logic [PTR_W-1:0] wr;
        evt_t             en;
        logic             ds256;
        logic             dir_up;
    } cfg_t;

    cfg_t c_d, c_q;

    logic       wr_base, wr_end, wr_wrp, wr_rdp, wr_ctrl, wr_stat;
    logic       key_wr;
    logic [PTR_W-1:0] rd_ptr_w;
    evt_t       stat_w;
    evt_t       evt_w;
    evt_t       clr_mask_w;

    always_comb begin
        wr_base = reg_wr_i && (reg_addr_i == RA_BASE);
        wr_end  = reg_wr_i && (reg_addr_i == RA_END);
        wr_wrp  = reg_wr_i && (reg_addr_i == RA_WRPTR);
        wr_rdp  = reg_wr_i && (reg_addr_i == RA_RDPTR);
        wr_ctrl = reg_wr_i && (reg_addr_i == RA_CTRL);
        wr_stat = reg_wr_i && (reg_addr_i == RA_STAT);
        key_wr  = wr_rdp && (reg_wdata_i == RD_RESET_KEY);
    end

    always_comb begin
        c_d = c_q;
        if (wr_base) c_d.base  = reg_wdata_i;
        if (wr_end)  c_d.end_p = reg_wdata_i[PTR_W-1:0];
        if (wr_wrp)  c_d.wr    = reg_wdata_i[PTR_W-1:0];
        if (wr_ctrl) begin
            c_d.en     = reg_wdata_i[EV_LSB+2:EV_LSB];
            c_d.ds256  = reg_wdata_i[CT_DS256];
            c_d.dir_up = reg_wdata_i[CT_DIR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    ring_rdptr #(.PTR_W(PTR_W), .STRIDE(STRIDE)) u_rdptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .consume_i (consume_i),
        .key_wr_i  (key_wr),
        .wr_ptr_i  (c_q.wr),
        .end_ptr_i (c_q.end_p),
        .rd_ptr_o  (rd_ptr_w)
    );

    assign evt_w      = '{dirty: dn_dirty_i, dn: dn_done_i, up: up_done_i};
    assign clr_mask_w = reg_wdata_i[EV_LSB+2:EV_LSB];

    ring_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_w),
        .clr_wr_i   (wr_stat),
        .clr_mask_i (clr_mask_w),
        .en_i       (c_q.en),
        .status_o   (stat_w),
        .irq_o      (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            RA_BASE:  reg_rdata_o = c_q.base;
            RA_END:   reg_rdata_o = {{PAD_W{1'b0}}, c_q.end_p};
            RA_WRPTR: reg_rdata_o = {{PAD_W{1'b0}}, c_q.wr};
            RA_RDPTR: reg_rdata_o = {{PAD_W{1'b0}}, rd_ptr_w};
            RA_CTRL: begin
                reg_rdata_o[EV_LSB+2:EV_LSB] = c_q.en;
                reg_rdata_o[CT_DS256]        = c_q.ds256;
                reg_rdata_o[CT_DIR]          = c_q.dir_up;
            end
            RA_STAT:  reg_rdata_o[EV_LSB+2:EV_LSB] = stat_w;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign xfer_fail_o  = stat_w.dirty;
    assign xfer_ok_o    = !stat_w.dirty && (c_q.dir_up ? stat_w.up : stat_w.dn);
    assign ds_256_o     = c_q.ds256;
    assign queue_base_o = c_q.base;
    assign head_ptr_o   = rd_ptr_w;
endmodule

// File: rtl/ring_cmdq_tracker_chk.sv
module ring_cmdq_tracker_chk
    import ring_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int STRIDE = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr_i,
    input logic [REG_ADDR_W-1:0] reg_addr_i,
    input logic [31:0]           reg_wdata_i,
    input logic                  consume_i,
    input logic                  up_done_i,
    input logic [PTR_W-1:0]      rd_ptr,
    input logic [PTR_W-1:0]      wr_ptr,
    input logic [2:0]            stat,
    input logic                  irq_o,
    input logic                  xfer_ok_o,
    input logic                  xfer_fail_o
);
    logic key_w;
    assign key_w = reg_wr_i && (reg_addr_i == RA_RDPTR) && (reg_wdata_i == RD_RESET_KEY);

    AST_KEY_ZEROES_RD: assert property (@(posedge clk) disable iff (!rst_n)
        key_w |=> (rd_ptr == '0)); // R6

    AST_EMPTY_HOLDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && (rd_ptr == wr_ptr) && !key_w) |=> $stable(rd_ptr)); // R4

    AST_RD_STEP_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr != $past(rd_ptr)) |-> ((rd_ptr == '0) ||
            ({1'b0, rd_ptr} == {1'b0, $past(rd_ptr)} + (PTR_W+1)'(STRIDE)))); // R3

    AST_UP_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        up_done_i |=> stat[0]); // R8

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == 3'b000) |=> !irq_o); // R10

    AST_DIRTY_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        stat[2] |-> (xfer_fail_o && !xfer_ok_o)); // R11
endmodule

bind ring_cmdq_tracker ring_cmdq_tracker_chk #(.PTR_W(PTR_W), .STRIDE(STRIDE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .consume_i   (consume_i),
    .up_done_i   (up_done_i),
    .rd_ptr      (rd_ptr_w),
    .wr_ptr      (c_q.wr),
    .stat        (stat_w),
    .irq_o       (irq_o),
    .xfer_ok_o   (xfer_ok_o),
    .xfer_fail_o (xfer_fail_o)
);

// File: tb/tb_ring_cmdq_tracker.sv
module tb_ring_cmdq_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        consume = 1'b0;
    logic        up_done = 1'b0, dn_done = 1'b0, dn_dirty = 1'b0;
    logic [31:0] qbase;
    logic [15:0] head;
    logic        irq, ok, fail, ds256;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ring_cmdq_tracker dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .consume_i(consume),
        .up_done_i(up_done), .dn_done_i(dn_done), .dn_dirty_i(dn_dirty),
        .queue_base_o(qbase), .head_ptr_o(head), .irq_o(irq),
        .xfer_ok_o(ok), .xfer_fail_o(fail), .ds_256_o(ds256)
    );

    localparam logic [2:0] A_BASE = 0, A_END = 1, A_WR = 2, A_RD = 3, A_CTRL = 4, A_STAT = 5;
    localparam logic [31:0] KEY = 32'hEE88_2266;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic consume_one();
        @(negedge clk);
        consume = 1'b1;
        @(negedge clk);
        consume = 1'b0;
    endtask

    task automatic pulse(input logic u, input logic d, input logic x);
        @(negedge clk);
        up_done = u; dn_done = d; dn_dirty = x;
        @(negedge clk);
        up_done = 1'b0; dn_done = 1'b0; dn_dirty = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rreg(3'(a), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 outs", {28'h0, irq, ok, fail, ds256}, 32'h0);
        chk("R1 head", {16'h0, head}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wreg(A_BASE, 32'h8000_1000); rreg(A_BASE, v); chk("R2 base", v, 32'h8000_1000);
        chk("R2 base out", qbase, 32'h8000_1000);
        wreg(A_END, 32'h0001_0010);  rreg(A_END, v);  chk("R2 end trunc", v, 32'h0000_0010);
        wreg(A_CTRL, 32'hFFFF_FFFF); rreg(A_CTRL, v); chk("R2 ctrl mask", v, 32'h0017_0001);
        chk("R12 ds256 on", {31'h0, ds256}, 32'h1);
        wreg(A_CTRL, 32'h0);         chk("R12 ds256 off", {31'h0, ds256}, 32'h0);
    endtask

    task automatic t_ring();
        logic [31:0] v;
        // restart order: end, key, write pointer, control, base
        wreg(A_END, 32'd16); wreg(A_RD, KEY); wreg(A_WR, 32'd0); wreg(A_CTRL, 32'h0); wreg(A_BASE, 32'h4000);
        consume_one(); rreg(A_RD, v); chk("R4 empty consume", v, 32'd0);
        wreg(A_WR, 32'd14);
        consume_one(); rreg(A_RD, v); chk("R3 step", v, 32'd2);
        for (int i = 0; i < 6; i++) consume_one();
        rreg(A_RD, v); chk("R3 walk to 14", v, 32'd14);
        consume_one(); rreg(A_RD, v); chk("R4 caught up", v, 32'd14);
        wreg(A_WR, 32'd4);
        consume_one(); rreg(A_RD, v); chk("R5 wrap", v, 32'd0);
        consume_one(); consume_one();
        rreg(A_RD, v); chk("R3 after wrap", v, 32'd4);
        wreg(A_RD, 32'h0000_0000); rreg(A_RD, v); chk("R6 non-key ignored", v, 32'd4);
        wreg(A_RD, KEY);           rreg(A_RD, v); chk("R6 key", v, 32'd0);
        consume_one(); rreg(A_RD, v); chk("R3 from zero", v, 32'd2);
        // key and consume in one cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_RD; reg_wdata = KEY; consume = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; consume = 1'b0;
        rreg(A_RD, v); chk("R7 key beats consume", v, 32'd0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        wreg(A_CTRL, 32'h0);
        pulse(1, 0, 0); pulse(0, 1, 0); pulse(0, 0, 1);
        rreg(A_STAT, v); chk("R8 sticky", v, 32'h0007_0000);
        chk("R10 masked", {31'h0, irq}, 32'h0);
        wreg(A_STAT, 32'h0002_0000); rreg(A_STAT, v); chk("R9 w1c one", v, 32'h0005_0000);
        wreg(A_STAT, 32'h0000_0000); rreg(A_STAT, v); chk("R9 zero keeps", v, 32'h0005_0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0001_0000; up_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; up_done = 1'b0;
        rreg(A_STAT, v); chk("R9 set beats clear", v, 32'h0005_0000);
        wreg(A_STAT, 32'h0007_0000); rreg(A_STAT, v); chk("R9 clear all", v, 32'h0);
    endtask

    task automatic t_irq();
        wreg(A_CTRL, 32'h0001_0000);
        @(negedge clk); dn_done = 1'b1;
        @(negedge clk); dn_done = 1'b0;
        @(negedge clk); chk("R10 disabled source", {31'h0, irq}, 32'h0);
        @(negedge clk); up_done = 1'b1;
        @(negedge clk); up_done = 1'b0;
        chk("R10 one cycle late", {31'h0, irq}, 32'h0);
        @(negedge clk); chk("R10 raised", {31'h0, irq}, 32'h1);
        wreg(A_STAT, 32'h0001_0000);
        chk("R10 lag on clear", {31'h0, irq}, 32'h1);
        @(negedge clk); chk("R10 dropped", {31'h0, irq}, 32'h0);
        wreg(A_STAT, 32'h0007_0000);
    endtask

    task automatic t_result();
        wreg(A_CTRL, 32'h0000_0001);
        pulse(0, 1, 0);
        chk("R11 wrong dir", {30'h0, ok, fail}, 32'h0);
        pulse(1, 0, 0);
        chk("R11 up ok", {30'h0, ok, fail}, 32'h2);
        pulse(0, 0, 1);
        chk("R11 dirty wins", {30'h0, ok, fail}, 32'h1);
        wreg(A_STAT, 32'h0007_0000);
        wreg(A_CTRL, 32'h0000_0000);
        pulse(0, 1, 0);
        chk("R11 dn ok", {30'h0, ok, fail}, 32'h2);
        wreg(A_STAT, 32'h0007_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_ring();
        t_status();
        t_irq();
        t_result();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule